// File: doc/BRIEF.md
# Exhaustive-Search Column Repair Sequencer

This block computes a soft repair setting for an SRAM whose word is split into a low half and a high half. Each half has one spare column. The only view of memory health it has is a self-test engine that returns a single pass/fail verdict per run. That verdict does not say which column failed. The sequencer finds the faulty column in each half by trying candidate settings and rerunning the self-test after each one.

A run begins when `go` is pulsed. The first self-test always runs with no repair applied and with both halves compared. If that test passes, the memory is reported as fault-free. Otherwise the low half is searched with the high half's spare disabled and its comparison masked. The high half is then searched the same way, with the low half's chosen spare kept in place. Splitting the search this way limits a full search to 1 + WORD_W self-test runs.

The repair setting is held on the configuration outputs. Pulsing `go` again recomputes it at any time. There is no data stream through this block. Every pin is a plain control or status level, or a one-cycle strobe, and nothing needs back-pressure.

Top module: `sram_repair_seeker`

## Requirements
- R1: After reset the block is idle. `busy`, `done`, `bist_start`, `repaired`, `unrepairable`, both enables and both indices are 0, and `cmp_mask` is 2'b11.
- R2: `bist_start` is high for exactly one cycle per self-test run, and only while `busy` is high. A `go` sampled while idle or done makes `bist_start` high in the next cycle.
- R3: The first run after `go` has both spare enables at 0 and `cmp_mask` = 2'b11 (bit 0 = low half compared, bit 1 = high half compared).
- R4: If the first run passes, the block enters done with `repaired` = 0, `unrepairable` = 0 and both enables at 0. `done` and `busy` are never high together.
- R5: The low-half search uses `cmp_mask` = 2'b01, `lo_rep_en` = 1 and `hi_rep_en` = 0. It tries `lo_rep_idx` = 0, 1, … WORD_W/2-1 in ascending order, one run each, and stops at the first index that passes.
- R6: The high-half search uses `cmp_mask` = 2'b10. It keeps `lo_rep_en` = 1 with the low index that was found, and tries `hi_rep_idx` = 0 upward in ascending order, one run each.
- R7: When the high-half search passes, the block enters done with `repaired` = 1, both enables at 1, both indices held at the passing values, and `cmp_mask` = 2'b11.
- R8: If every candidate of a half fails, the block enters done with `unrepairable` = 1, `repaired` = 0, both enables at 0 and both indices at 0.
- R9: A new run is not started while a self-test is outstanding. `bist_pass` is used only in a cycle where `bist_done` answers an outstanding run. A `bist_done` pulse while idle or done changes nothing.
- R10: A `go` pulse while `busy` is high is ignored. The run in progress keeps its sequence and result.
- R11: The number of self-test runs in one search never exceeds 1 + WORD_W.
- R12: A `go` in the done state restarts the whole sequence from the unrepaired first run and recomputes the setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start or restart the repair search (pulse) |
| bist_start | output | 1 | One-cycle request for a self-test run |
| bist_done | input | 1 | Self-test run finished, verdict valid |
| bist_pass | input | 1 | Self-test verdict, 1 = pass |
| cmp_mask | output | 2 | Halves the self-test must judge (bit 0 low, bit 1 high) |
| lo_rep_en | output | 1 | Low-half spare column enabled |
| lo_rep_idx | output | $clog2(WORD_W/2) | Low-half column replaced by the spare |
| hi_rep_en | output | 1 | High-half spare column enabled |
| hi_rep_idx | output | $clog2(WORD_W/2) | High-half column replaced by the spare |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, result outputs valid |
| repaired | output | 1 | A passing repair setting was found |
| unrepairable | output | 1 | No candidate fixed a faulty half |

## Verification
The bench aims at faults sitting on the last candidate of each half. A design with an off-by-one counter would either stop one index short and declare the part unrepairable, or wrap to index 0 and loop. It runs a fault confined to the high half, which the low-half search must clear at index 0. A design that skipped the high-half phase, or failed to keep the low spare in place during it, would lose the repair. It also covers an unfixable half after a valid low repair, checking that every enable is cleared. A stray `go` mid-search and a stray `bist_done` after completion test that neither restarts nor alters a result. Any of those faults would show up as a surplus or missing self-test run in the model's expected launch sequence.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_WAIT   = 2'd2,
    ST_DONE   = 2'd3
  } srs_state_t;

  typedef enum logic [1:0] {
    PH_BASE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } srs_phase_t;
endpackage

// File: rtl/srs_cand_ctr.sv
// Candidate column index and enable for one half word.
module srs_cand_ctr #(
  parameter int HALF = 8,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          begin_i,
  input  logic          step_i,
  output logic          en_o,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);
  localparam logic [IW-1:0] LAST_IDX = IW'(HALF - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o  <= 1'b0;
      idx_o <= '0;
    end else if (clr_i) begin
      en_o  <= 1'b0;
      idx_o <= '0;
    end else if (begin_i) begin
      en_o  <= 1'b1;
      idx_o <= '0;
    end else if (step_i) begin
      idx_o <= idx_o + 1'b1;
    end
  end

  assign last_o = (idx_o == LAST_IDX);
endmodule

// File: rtl/srs_bist_link.sv
// Start strobe and verdict qualification for the self-test handshake.
module srs_bist_link (
  input  logic clk,
  input  logic rst_n,
  input  logic launch_i,
  input  logic bist_done_i,
  input  logic bist_pass_i,
  output logic bist_start_o,
  output logic verdict_vld_o,
  output logic verdict_pass_o
);
  logic waiting_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            waiting_q <= 1'b0;
    else if (launch_i)     waiting_q <= 1'b1;
    else if (bist_done_i)  waiting_q <= 1'b0;
  end

  assign bist_start_o   = launch_i;
  assign verdict_vld_o  = waiting_q & bist_done_i;
  assign verdict_pass_o = bist_pass_i;
endmodule

// File: rtl/sram_repair_seeker.sv
module sram_repair_seeker
  import srs_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int HALF = WORD_W / 2,
  localparam int IW   = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  output logic          bist_start,
  input  logic          bist_done,
  input  logic          bist_pass,
  output logic [1:0]    cmp_mask,
  output logic          lo_rep_en,
  output logic [IW-1:0] lo_rep_idx,
  output logic          hi_rep_en,
  output logic [IW-1:0] hi_rep_idx,
  output logic          busy,
  output logic          done,
  output logic          repaired,
  output logic          unrepairable
);
  srs_state_t st_q, st_n;
  srs_phase_t ph_q, ph_n;
  logic [1:0] mask_q, mask_n;
  logic       rep_q, rep_n, unr_q, unr_n;
  logic       vrd_vld, vrd_pass;

  logic [1:0]    c_clr, c_begin, c_step, c_en, c_last;
  logic [IW-1:0] c_idx [2];

  srs_bist_link u_link (
    .clk            (clk),
    .rst_n          (rst_n),
    .launch_i       (st_q == ST_LAUNCH),
    .bist_done_i    (bist_done),
    .bist_pass_i    (bist_pass),
    .bist_start_o   (bist_start),
    .verdict_vld_o  (vrd_vld),
    .verdict_pass_o (vrd_pass)
  );

  for (genvar h = 0; h < 2; h++) begin : g_half
    srs_cand_ctr #(.HALF(HALF), .IW(IW)) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (c_clr[h]),
      .begin_i (c_begin[h]),
      .step_i  (c_step[h]),
      .en_o    (c_en[h]),
      .idx_o   (c_idx[h]),
      .last_o  (c_last[h])
    );
  end

  always_comb begin
    st_n    = st_q;
    ph_n    = ph_q;
    mask_n  = mask_q;
    rep_n   = rep_q;
    unr_n   = unr_q;
    c_clr   = '0;
    c_begin = '0;
    c_step  = '0;
    case (st_q)
      ST_IDLE, ST_DONE: begin
        if (go) begin
          st_n   = ST_LAUNCH;
          ph_n   = PH_BASE;
          mask_n = 2'b11;
          rep_n  = 1'b0;
          unr_n  = 1'b0;
          c_clr  = 2'b11;
        end
      end
      ST_LAUNCH: st_n = ST_WAIT;
      ST_WAIT: begin
        if (vrd_vld) begin
          case (ph_q)
            PH_BASE: begin
              if (vrd_pass) begin
                st_n = ST_DONE;
              end else begin
                ph_n       = PH_LO;
                mask_n     = 2'b01;
                c_begin[0] = 1'b1;
                st_n       = ST_LAUNCH;
              end
            end
            PH_LO: begin
              if (vrd_pass) begin
                ph_n       = PH_HI;
                mask_n     = 2'b10;
                c_begin[1] = 1'b1;
                st_n       = ST_LAUNCH;
              end else if (c_last[0]) begin
                c_clr  = 2'b11;
                unr_n  = 1'b1;
                mask_n = 2'b11;
                st_n   = ST_DONE;
              end else begin
                c_step[0] = 1'b1;
                st_n      = ST_LAUNCH;
              end
            end
            PH_HI: begin
              if (vrd_pass) begin
                rep_n  = 1'b1;
                mask_n = 2'b11;
                st_n   = ST_DONE;
              end else if (c_last[1]) begin
                c_clr  = 2'b11;
                unr_n  = 1'b1;
                mask_n = 2'b11;
                st_n   = ST_DONE;
              end else begin
                c_step[1] = 1'b1;
                st_n      = ST_LAUNCH;
              end
            end
            default: st_n = ST_IDLE;
          endcase
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_BASE;
      mask_q <= 2'b11;
      rep_q  <= 1'b0;
      unr_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      mask_q <= mask_n;
      rep_q  <= rep_n;
      unr_q  <= unr_n;
    end
  end

  assign cmp_mask     = mask_q;
  assign lo_rep_en    = c_en[0];
  assign lo_rep_idx   = c_idx[0];
  assign hi_rep_en    = c_en[1];
  assign hi_rep_idx   = c_idx[1];
  assign busy         = (st_q == ST_LAUNCH) || (st_q == ST_WAIT);
  assign done         = (st_q == ST_DONE);
  assign repaired     = rep_q;
  assign unrepairable = unr_q;
endmodule

// File: rtl/srs_checker.sv
module srs_checker #(
  parameter int WORD_W = 16,
  localparam int HALF = WORD_W / 2,
  localparam int IW   = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int RW   = $clog2(WORD_W + 2) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic          bist_start,
  input logic          bist_done,
  input logic [1:0]    cmp_mask,
  input logic          lo_rep_en,
  input logic [IW-1:0] lo_rep_idx,
  input logic          hi_rep_en,
  input logic          busy,
  input logic          done,
  input logic          repaired,
  input logic          unrepairable
);
  logic          outstanding_q, first_q;
  logic [RW-1:0] runs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outstanding_q <= 1'b0;
      first_q       <= 1'b0;
      runs_q        <= '0;
    end else begin
      if (bist_start)     outstanding_q <= 1'b1;
      else if (bist_done) outstanding_q <= 1'b0;
      if (go && !busy)     first_q <= 1'b1;
      else if (bist_start) first_q <= 1'b0;
      if (go && !busy)     runs_q <= '0;
      else if (bist_start) runs_q <= runs_q + 1'b1;
    end
  end

  // R2
  a_r2_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start |=> !bist_start);
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    bist_start |-> busy);
  // R3
  a_r3_first_unrepaired: assert property (@(posedge clk) disable iff (!rst_n)
    (first_q && bist_start) |-> (!lo_rep_en && !hi_rep_en && cmp_mask == 2'b11));
  // R4
  a_r4_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R5
  a_r5_lo_phase_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmp_mask == 2'b01) |-> (lo_rep_en && !hi_rep_en));
  // R6
  a_r6_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmp_mask == 2'b10) |-> (lo_rep_en && hi_rep_en && $stable(lo_rep_idx)));
  // R7
  a_r7_repaired_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    repaired |-> (lo_rep_en && hi_rep_en && !unrepairable));
  // R8
  a_r8_unrep_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    unrepairable |-> (!lo_rep_en && !hi_rep_en && !repaired));
  // R9
  a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding_q |-> !bist_start);
  // R11
  a_r11_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    runs_q <= RW'(WORD_W + 1));
endmodule

bind sram_repair_seeker srs_checker #(.WORD_W(WORD_W)) u_srs_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .go           (go),
  .bist_start   (bist_start),
  .bist_done    (bist_done),
  .cmp_mask     (cmp_mask),
  .lo_rep_en    (lo_rep_en),
  .lo_rep_idx   (lo_rep_idx),
  .hi_rep_en    (hi_rep_en),
  .busy         (busy),
  .done         (done),
  .repaired     (repaired),
  .unrepairable (unrepairable)
);

// File: tb/sram_repair_seeker_bench.sv
module sram_repair_seeker_bench;
  localparam int W  = 16;
  localparam int H  = W / 2;
  localparam int IW = $clog2(H);
  localparam int CW = 4 + 2 * IW;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
  logic bist_start, bist_done = 1'b0, bist_pass = 1'b0;
  logic [1:0] cmp_mask;
  logic lo_rep_en, hi_rep_en, busy, done, repaired, unrepairable;
  logic [IW-1:0] lo_rep_idx, hi_rep_idx;

  always #4 clk = ~clk;

  sram_repair_seeker #(.WORD_W(W)) u_sram_repair_seeker (
    .clk(clk), .rst_n(rst_n), .go(go), .bist_start(bist_start),
    .bist_done(bist_done), .bist_pass(bist_pass), .cmp_mask(cmp_mask),
    .lo_rep_en(lo_rep_en), .lo_rep_idx(lo_rep_idx), .hi_rep_en(hi_rep_en),
    .hi_rep_idx(hi_rep_idx), .busy(busy), .done(done), .repaired(repaired),
    .unrepairable(unrepairable)
  );

  int nchk = 0, nbad = 0, cycles = 0;
  int flo = -1, fhi = -1, lat = 2, runs = 0;
  logic [CW-1:0] expq[$];
  bit e_rep, e_unr;
  int e_lo, e_hi, e_runs;

  task automatic chk(string req, int got, int exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  function automatic bit half_ok(int f, bit en, int idx);
    if (f < 0) return 1'b1;
    if (f >= H) return 1'b0;
    return en && (idx == f);
  endfunction

  function automatic logic [CW-1:0] cfg(logic [1:0] m, bit le, int li, bit he, int hi);
    return {m, le, IW'(li), he, IW'(hi)};
  endfunction

  // Behavioural reference: list of expected launch settings and final result.
  task automatic build();
    int lo_found = -1, hi_found = -1;
    expq.delete();
    e_rep = 0; e_unr = 0; e_lo = 0; e_hi = 0;
    expq.push_back(cfg(2'b11, 0, 0, 0, 0));
    if (half_ok(flo, 0, 0) && half_ok(fhi, 0, 0)) begin
      e_runs = 1;
      return;
    end
    for (int i = 0; i < H; i++) begin
      expq.push_back(cfg(2'b01, 1, i, 0, 0));
      if (half_ok(flo, 1, i)) begin lo_found = i; break; end
    end
    if (lo_found >= 0) begin
      for (int j = 0; j < H; j++) begin
        expq.push_back(cfg(2'b10, 1, lo_found, 1, j));
        if (half_ok(fhi, 1, j)) begin hi_found = j; break; end
      end
    end
    e_runs = expq.size();
    if (lo_found >= 0 && hi_found >= 0) begin
      e_rep = 1; e_lo = lo_found; e_hi = hi_found;
    end else begin
      e_unr = 1;
    end
  endtask

  // Self-test stub: checks each launch against the model, answers after lat cycles.
  initial begin
    forever begin
      @(negedge clk);
      bist_done = 1'b0;
      bist_pass = 1'b0;
      if (rst_n && bist_start) begin
        logic [CW-1:0] got;
        bit p;
        runs++;
        got = {cmp_mask, lo_rep_en, lo_rep_idx, hi_rep_en, hi_rep_idx};
        if (expq.size() == 0) chk("R11 unexpected extra run", 1, 0);
        else chk("R5 R6 launch setting", int'(got), int'(expq.pop_front()));
        p = (!cmp_mask[0] || half_ok(flo, lo_rep_en, int'(lo_rep_idx))) &&
            (!cmp_mask[1] || half_ok(fhi, hi_rep_en, int'(hi_rep_idx)));
        repeat (lat - 1) @(negedge clk);
        bist_done = 1'b1;
        bist_pass = p;
      end
    end
  end

  // Every-clock relations.
  always @(negedge clk) begin
    if (rst_n) begin
      cycles++;
      if (busy && done) chk("R4 busy with done", 1, 0);
      if (bist_start && !busy) chk("R2 start outside busy", 1, 0);
      if (cycles > 100000) begin
        chk("watchdog", 1, 0);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
      end
    end
  end

  task automatic run_case(string tag, int fl, int fh, int l, bit poke);
    int guard = 0;
    flo = fl; fhi = fh; lat = l; runs = 0;
    build();
    @(negedge clk) go = 1'b1;
    @(negedge clk) go = 1'b0;
    chk({tag, " R2 busy after go"}, int'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      go = 1'b1;                 // R10: ignored while busy
      @(negedge clk) go = 1'b0;
    end
    while (!done && guard < 2000) begin @(negedge clk); guard++; end
    chk({tag, " R11 run count"}, runs, e_runs);
    chk({tag, " R11 bound"}, int'(runs <= W + 1), 1);
    chk({tag, " R5 R6 all launches seen"}, expq.size(), 0);
    chk({tag, " R7 repaired"}, int'(repaired), int'(e_rep));
    chk({tag, " R8 unrepairable"}, int'(unrepairable), int'(e_unr));
    chk({tag, " R7 R8 lo enable"}, int'(lo_rep_en), int'(e_rep));
    chk({tag, " R7 R8 hi enable"}, int'(hi_rep_en), int'(e_rep));
    chk({tag, " R7 lo index"}, int'(lo_rep_idx), e_lo);
    chk({tag, " R7 hi index"}, int'(hi_rep_idx), e_hi);
    chk({tag, " R7 mask restored"}, int'(cmp_mask), 3);
    chk({tag, " R4 not busy"}, int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 start", int'(bist_start), 0);
    chk("R1 flags", int'({repaired, unrepairable}), 0);
    chk("R1 enables", int'({lo_rep_en, hi_rep_en}), 0);
    chk("R1 indices", int'({lo_rep_idx, hi_rep_idx}), 0);
    chk("R1 mask", int'(cmp_mask), 3);
    rst_n = 1'b1;
    @(negedge clk);
    run_case("R3 R4 clean", -1, -1, 2, 0);
    run_case("R5 lo fault", 5, -1, 3, 0);
    run_case("R6 hi last column", -1, H - 1, 2, 0);
    run_case("R10 both faults", H - 1, 0, 4, 1);
    run_case("R8 lo dead", 99, -1, 2, 0);
    run_case("R8 R11 hi dead worst", H - 1, 99, 3, 0);
    run_case("R12 restart", 3, 4, 2, 0);
    // R9: stray verdict while done must not change anything.
    @(negedge clk) begin bist_done = 1'b1; bist_pass = 1'b0; end
    repeat (2) @(negedge clk);
    chk("R9 stray done keeps repaired", int'(repaired), 1);
    chk("R9 stray done keeps done", int'(done), 1);
    chk("R9 stray done keeps lo index", int'(lo_rep_idx), 3);
    chk("R9 stray done no launch", runs, e_runs);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule